// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a single-cycle registered datapath for an integer vector unit. It takes a vector of 32-bit accumulator lanes and two source vectors of the same width. Each lane takes four byte pairs from the same positions in the two sources and multiplies each pair separately. The four products are summed, and the sum is added to the lane's current value. The default vector is 128 bits, which gives four lanes, and the `LANES` parameter widens it.

The operation is chosen by an opcode byte, a two-bit prefix class and a W bit. The opcode picks the accumulation form: a wrapping form, or a saturating form that clamps the exact result. The prefix class picks the signedness of each source byte. An encoding outside the defined set sets the illegal flag, and the accumulator passes through unchanged. Results, the illegal flag and an output valid appear one clock after an accepted input.

Top module: `byte_dot_acc`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `illegal_o` and `acc_o` are all zero.
- R2: For an input accepted with `valid_i` high, `valid_o` is high on the next cycle. Lane n of `acc_o` (bits 32n+31..32n) is then formed from bytes 4n..4n+3 of `src_a_i` and `src_b_i`, where byte k is bits 8k+7..8k, plus lane n of `acc_i`.
- R3: Prefix class 2'b10 is signed×signed: bytes of both sources are sign-extended before multiplying.
- R4: Prefix class 2'b11 is signed×unsigned: `src_a_i` bytes are sign-extended and `src_b_i` bytes are zero-extended.
- R5: Prefix class 2'b01 is unsigned×signed: `src_a_i` bytes are zero-extended and `src_b_i` bytes are sign-extended.
- R6: Prefix class 2'b00 is unsigned×unsigned: both bytes are zero-extended, and the accumulator lane is read as unsigned.
- R7: Opcode 8'h50 selects the wrapping form: the lane result is the exact sum modulo 2^32.
- R8: Opcode 8'h51 with prefix class 2'b01, 2'b10 or 2'b11 saturates signed. An exact result above 0x7FFFFFFF gives 0x7FFFFFFF, and one below -2^31 gives 0x80000000.
- R9: Opcode 8'h51 with prefix class 2'b00 saturates unsigned: an exact result above 0xFFFFFFFF gives 0xFFFFFFFF.
- R10: The mode depends only on the opcode (8'h50 or 8'h51), the prefix class and the W bit. Both opcodes use the same prefix-class-to-signedness mapping.
- R11: When `wbit_i` is 1, or the opcode is neither 8'h50 nor 8'h51, `illegal_o` is 1 on the next cycle and every lane of `acc_o` equals the `acc_i` that was applied.
- R12: While `valid_i` is low, `valid_o` is low on the next cycle, and `acc_o` and `illegal_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input operation valid |
| opcode_i | input | 8 | Opcode byte (8'h50 wrap, 8'h51 saturate) |
| pfx_i | input | 2 | Prefix class: 00 none, 01 0x66, 10 0xF3, 11 0xF2 |
| wbit_i | input | 1 | Vector W bit; must be 0 for a legal form |
| acc_i | input | 32*LANES | Accumulator input lanes |
| src_a_i | input | 32*LANES | First source bytes |
| src_b_i | input | 32*LANES | Second source bytes |
| valid_o | output | 1 | Result valid |
| acc_o | output | 32*LANES | Accumulated result lanes |
| illegal_o | output | 1 | Illegal encoding flag for the last accepted input |

## Verification
Some directed vectors have a single nonzero byte per position or ramp values across bytes, and these expose any lane or byte mis-mapping. Operands of 0x80 and 0xFF tell the four signedness modes apart, because each extension choice flips the sign or the size of the product. Accumulators placed next to the signed and unsigned limits show whether the clamp or the wrap is taken, and from which side. Random operands, opcodes, prefix classes and W bits then mix legal forms with illegal ones, including back-to-back changes of mode, against a reference model in the bench.

// File: rtl/byte_dot_pkg.sv
package byte_dot_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned BYTES_PER_LANE = LANE_W / 8;

  localparam logic [7:0] OPC_WRAP = 8'h50;
  localparam logic [7:0] OPC_SAT  = 8'h51;

  typedef enum logic [1:0] {
    PFX_NONE = 2'b00,
    PFX_66   = 2'b01,
    PFX_F3   = 2'b10,
    PFX_F2   = 2'b11
  } pfx_cls_e;

  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic saturate;
    logic illegal;
  } dot_mode_t;
endpackage

// File: rtl/byte_dot_decode.sv
module byte_dot_decode
  import byte_dot_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  logic [1:0] pfx_i,
  input  logic       wbit_i,
  output dot_mode_t  mode_o
);
  always_comb begin
    mode_o = '0;
    unique case (pfx_cls_e'(pfx_i))
      PFX_NONE: begin mode_o.a_signed = 1'b0; mode_o.b_signed = 1'b0; end
      PFX_66:   begin mode_o.a_signed = 1'b0; mode_o.b_signed = 1'b1; end
      PFX_F3:   begin mode_o.a_signed = 1'b1; mode_o.b_signed = 1'b1; end
      PFX_F2:   begin mode_o.a_signed = 1'b1; mode_o.b_signed = 1'b0; end
      default:  begin mode_o.a_signed = 1'b0; mode_o.b_signed = 1'b0; end
    endcase
    mode_o.saturate = (opcode_i == OPC_SAT);
    mode_o.illegal  = wbit_i | ((opcode_i != OPC_WRAP) && (opcode_i != OPC_SAT));
  end
endmodule

// File: rtl/byte_dot_lane.sv
module byte_dot_lane
  import byte_dot_pkg::*;
(
  input  logic [LANE_W-1:0] acc_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  input  logic              sat_i,
  output logic [LANE_W-1:0] res_o
);
  localparam int unsigned PROD_W = 18;
  localparam int unsigned SUM_W  = LANE_W + 2;
  localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] U_MAX = {LANE_W{1'b1}};

  logic signed [PROD_W-1:0] prod [BYTES_PER_LANE];

  for (genvar k = 0; k < BYTES_PER_LANE; k++) begin : g_byte
    logic signed [8:0] ea, eb;
    assign ea = {a_signed_i & a_i[8*k+7], a_i[8*k +: 8]};
    assign eb = {b_signed_i & b_i[8*k+7], b_i[8*k +: 8]};
    assign prod[k] = ea * eb;
  end

  logic              acc_signed;
  logic [SUM_W-1:0]  dot, acc_x, total;

  assign acc_signed = a_signed_i | b_signed_i;

  always_comb begin
    dot = '0;
    for (int k = 0; k < BYTES_PER_LANE; k++)
      dot = dot + {{(SUM_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    acc_x = {{2{acc_signed & acc_i[LANE_W-1]}}, acc_i};
    total = acc_x + dot;
  end

  // signed overflow: top three bits disagree; unsigned: bits above lane set
  always_comb begin
    res_o = total[LANE_W-1:0];
    if (sat_i) begin
      if (acc_signed) begin
        if (total[SUM_W-1:LANE_W-1] != {3{total[SUM_W-1]}})
          res_o = total[SUM_W-1] ? S_MIN : S_MAX;
      end else if (|total[SUM_W-1:LANE_W]) begin
        res_o = U_MAX;
      end
    end
  end
endmodule

// File: rtl/byte_dot_acc.sv
module byte_dot_acc
  import byte_dot_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [7:0]              opcode_i,
  input  logic [1:0]              pfx_i,
  input  logic                    wbit_i,
  input  logic [LANES*LANE_W-1:0] acc_i,
  input  logic [LANES*LANE_W-1:0] src_a_i,
  input  logic [LANES*LANE_W-1:0] src_b_i,
  output logic                    valid_o,
  output logic [LANES*LANE_W-1:0] acc_o,
  output logic                    illegal_o
);
  localparam int unsigned VEC_W = LANES * LANE_W;

  dot_mode_t        mode;
  logic [VEC_W-1:0] lane_res;

  byte_dot_decode u_dec (
    .opcode_i (opcode_i),
    .pfx_i    (pfx_i),
    .wbit_i   (wbit_i),
    .mode_o   (mode)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    byte_dot_lane u_lane (
      .acc_i      (acc_i[l*LANE_W +: LANE_W]),
      .a_i        (src_a_i[l*LANE_W +: LANE_W]),
      .b_i        (src_b_i[l*LANE_W +: LANE_W]),
      .a_signed_i (mode.a_signed),
      .b_signed_i (mode.b_signed),
      .sat_i      (mode.saturate),
      .res_o      (lane_res[l*LANE_W +: LANE_W])
    );

    // R9: unsigned saturating form never goes below the old lane value
    a_r9_uu_sat_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !wbit_i && opcode_i == OPC_SAT && pfx_i == 2'b00)
      |=> acc_o[l*LANE_W +: LANE_W] >= $past(acc_i[l*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      acc_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= mode.illegal;
        acc_o     <= mode.illegal ? acc_i : lane_res;
      end
    end
  end

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(acc_o) && $stable(illegal_o));

  a_r11_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (wbit_i || (opcode_i != OPC_WRAP && opcode_i != OPC_SAT)))
    |=> illegal_o && acc_o == $past(acc_i));

  a_r2_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r7_zero_src_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wbit_i && opcode_i == OPC_WRAP && src_b_i == '0)
    |=> !illegal_o && acc_o == $past(acc_i));
endmodule

// File: tb/byte_dot_acc_tb.sv
module byte_dot_acc_tb;
  localparam int LANES = 4;
  localparam int VW = LANES * 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [7:0]    opcode_i = '0;
  logic [1:0]    pfx_i = '0;
  logic          wbit_i = 1'b0;
  logic [VW-1:0] acc_i = '0, src_a_i = '0, src_b_i = '0;
  logic          valid_o, illegal_o;
  logic [VW-1:0] acc_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  byte_dot_acc #(.LANES(LANES)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .pfx_i(pfx_i), .wbit_i(wbit_i), .acc_i(acc_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .valid_o(valid_o), .acc_o(acc_o), .illegal_o(illegal_o)
  );

  function automatic bit is_illegal(logic [7:0] op, logic w);
    return w || (op != 8'h50 && op != 8'h51);
  endfunction

  function automatic logic [VW-1:0] ref_calc(logic [7:0] op, logic [1:0] pfx, logic w,
      logic [VW-1:0] acc, logic [VW-1:0] a, logic [VW-1:0] b);
    logic [VW-1:0] r;
    bit as_, bs_;
    if (is_illegal(op, w)) return acc;
    as_ = pfx[1];
    bs_ = pfx[0] ^ pfx[1];
    for (int l = 0; l < LANES; l++) begin
      longint t;
      logic [31:0] a32;
      a32 = acc[l*32 +: 32];
      t = (as_ || bs_) ? longint'($signed(a32)) : longint'(a32);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] x8, y8;
        longint x, y;
        x8 = a[l*32+8*k +: 8];
        y8 = b[l*32+8*k +: 8];
        x = as_ ? longint'($signed(x8)) : longint'(x8);
        y = bs_ ? longint'($signed(y8)) : longint'(y8);
        t = t + x * y;
      end
      if (op == 8'h51) begin
        if (as_ || bs_) begin
          if (t > 64'sd2147483647) t = 64'sd2147483647;
          if (t < -64'sd2147483648) t = -64'sd2147483648;
        end else if (t > 64'sd4294967295) t = 64'sd4294967295;
      end
      r[l*32 +: 32] = t[31:0];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [VW-1:0] got, logic [VW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(string req, logic [7:0] op, logic [1:0] pfx, logic w,
      logic [VW-1:0] acc, logic [VW-1:0] a, logic [VW-1:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = op; pfx_i = pfx; wbit_i = w;
    acc_i = acc; src_a_i = a; src_b_i = b;
    @(posedge clk_i); #1;
    chk({req, " acc"}, acc_o, ref_calc(op, pfx, w, acc, a, b));
    chk({req, " illegal"}, VW'(illegal_o), VW'(is_illegal(op, w)));
    chk({req, " valid"}, VW'(valid_o), VW'(1));
  endtask

  function automatic logic [VW-1:0] rep(logic [7:0] v);
    return {(VW/8){v}};
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] ramp, held;
    void'($urandom(32'd4242));
    #20;
    // R1 reset state
    chk("R1 acc", acc_o, '0);
    chk("R1 valid/illegal", VW'({valid_o, illegal_o}), '0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 byte-to-lane mapping with a ramp
    for (int i = 0; i < VW/8; i++) ramp[8*i +: 8] = 8'(i + 1);
    run_op("R2 ramp", 8'h50, 2'b00, 1'b0, '0, ramp, rep(8'h01));
    chk("R2 lane3", {96'd0, acc_o[127:96]}, {96'd0, 32'd58});
    run_op("R2 single byte", 8'h50, 2'b00, 1'b0, 128'h1, 128'h0000_0000_0300_0000_0000_0000_0000_0000,
           128'h0000_0000_0500_0000_0000_0000_0000_0000);

    // R3..R6 signedness with 0xFF and 0x80/0x01
    run_op("R3 ss ff", 8'h50, 2'b10, 1'b0, '0, rep(8'hFF), rep(8'hFF));
    chk("R3 lane0", {96'd0, acc_o[31:0]}, {96'd0, 32'd4});
    run_op("R4 su ff", 8'h50, 2'b11, 1'b0, '0, rep(8'hFF), rep(8'hFF));
    chk("R4 lane0", {96'd0, acc_o[31:0]}, {96'd0, 32'hFFFF_FC04});
    run_op("R4 su 80x01", 8'h50, 2'b11, 1'b0, '0, rep(8'h80), rep(8'h01));
    run_op("R5 us 80x01", 8'h50, 2'b01, 1'b0, '0, rep(8'h80), rep(8'h01));
    chk("R5 lane0", {96'd0, acc_o[31:0]}, {96'd0, 32'd512});
    run_op("R5 us ffxff", 8'h50, 2'b01, 1'b0, '0, rep(8'hFF), rep(8'hFF));
    run_op("R6 uu ff", 8'h50, 2'b00, 1'b0, '0, rep(8'hFF), rep(8'hFF));
    chk("R6 lane0", {96'd0, acc_o[31:0]}, {96'd0, 32'd260100});

    // R7 wrap
    run_op("R7 uu wrap", 8'h50, 2'b00, 1'b0, rep(8'hFF), rep(8'hFF), rep(8'hFF));
    chk("R7 lane1", {96'd0, acc_o[63:32]}, {96'd0, 32'd260099});
    run_op("R7 ss wrap", 8'h50, 2'b10, 1'b0, {4{32'h7FFF_FFF0}}, rep(8'h7F), rep(8'h7F));

    // R8 signed saturation both ends, R9 unsigned
    run_op("R8 ss max", 8'h51, 2'b10, 1'b0, {4{32'h7FFF_FFF0}}, rep(8'h7F), rep(8'h7F));
    chk("R8 lane2", {96'd0, acc_o[95:64]}, {96'd0, 32'h7FFF_FFFF});
    run_op("R8 su min", 8'h51, 2'b11, 1'b0, {4{32'h8000_0005}}, rep(8'h80), rep(8'hFF));
    chk("R8 lane0 min", {96'd0, acc_o[31:0]}, {96'd0, 32'h8000_0000});
    run_op("R8 us max", 8'h51, 2'b01, 1'b0, {4{32'h7FFF_FF00}}, rep(8'hFF), rep(8'h7F));
    run_op("R8 no clamp", 8'h51, 2'b10, 1'b0, {4{32'h0000_1000}}, rep(8'h80), rep(8'h7F));
    run_op("R9 uu sat", 8'h51, 2'b00, 1'b0, {4{32'hFFFF_FF00}}, rep(8'hFF), rep(8'hFF));
    chk("R9 lane0", {96'd0, acc_o[31:0]}, {96'd0, 32'hFFFF_FFFF});
    run_op("R9 uu no clamp", 8'h51, 2'b00, 1'b0, {4{32'h0000_0010}}, rep(8'h02), rep(8'h03));

    // R11 illegal encodings pass the accumulator through
    run_op("R11 w=1", 8'h50, 2'b10, 1'b1, rnd_vec(), rep(8'h11), rep(8'h22));
    run_op("R11 op52", 8'h52, 2'b00, 1'b0, rnd_vec(), rep(8'h11), rep(8'h22));
    run_op("R11 op4f", 8'h4F, 2'b11, 1'b0, rnd_vec(), rep(8'h11), rep(8'h22));

    // R12 hold while valid_i low
    held = acc_o;
    @(negedge clk_i);
    valid_i = 1'b0; acc_i = rnd_vec(); src_a_i = rnd_vec(); src_b_i = rnd_vec();
    opcode_i = 8'h50; wbit_i = 1'b0;
    @(posedge clk_i); #1;
    @(posedge clk_i); #1;
    chk("R12 acc hold", acc_o, held);
    chk("R12 valid low", VW'({valid_o, illegal_o}), VW'(2'b01));

    // R10 random mix of modes, opcodes and W bits
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      int sel;
      sel = int'($urandom % 10);
      op = (sel < 4) ? 8'h50 : (sel < 8) ? 8'h51 : 8'($urandom);
      run_op("R10 random", op, 2'($urandom), ($urandom % 8) == 0, rnd_vec(), rnd_vec(), rnd_vec());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule